// File: doc/BRIEF.md
# Training-Pattern Alignment Checker for an E-Link Group

This block sits on the back-end side of a deserialized e-link group. It checks whether the data of every channel in the group lands in the right bit positions and in the right 40 MHz frame. During training, the front-end drives a known pattern. Channel 0 of the group carries a fixed marker that fixes where the most significant bit sits. Every other channel carries the contribution of a 4-bit LFSR sequence, sized to the selected line rate. The checker runs the same generator locally and XORs the received group against it. It keeps 16 frames of its own generator history, so a group that arrives whole frames late is recognised and a frame offset is suggested.

One frame slice is presented per enabled clock. The checker reports three things: the XOR mismatch of the current frame at zero offset, the smallest history offset at which the whole group matches, and an aligned flag. The flag rises after an uninterrupted run of clean frames. Applying the suggested shift is left to the front-end.

Top module: `elink_group_aligner`

## Requirements
- R1: After reset `aligned_o` is 0, `xor_mism_o` is all zeros, `shift_sug_o` is all ones, and the local generator holds 4'b0001 as its first word.
- R2: The local word follows x^4 + x^3 + 1 (next = {w[2:0], w[3]^w[2]}) and advances once per frame with `frame_en_i` high. The expected byte of channel j ≥ 1 depends on `rate_sel_i`:
  - 2'b00 (80 Mb/s): bits [1:0] = w[1:0].
  - 2'b01 (160 Mb/s): bits [3:0] = w.
  - 2'b10 or 2'b11 (320 Mb/s): bits [7:0] = {w, w}.
- R3: Channel 0 carries the position marker instead of the LFSR word:
  - 2'b00: bits [1:0] = 2'b10.
  - 2'b01: bits [3:0] = 4'b1000.
  - 2'b10 or 2'b11: bits [7:0] = 8'h80.
- R4: Byte j of `xor_mism_o` is the XOR of byte j of `frame_i` with that channel's expected value at zero offset. It is registered at the enabled clock edge that samples the frame.
- R5: `aligned_o` rises at the edge that registers the 16th consecutive enabled frame with an all-zero mismatch. Any enabled frame with a nonzero mismatch clears it at that edge.
- R6: `shift_sug_o` gives the smallest k in 0..15 for which two conditions hold together: the marker channel matches, and every LFSR channel matches the word generated k frames earlier. Words from before reset count as zero.
- R7: When no k satisfies R6 (for example a wrong marker), `shift_sug_o` is all ones (31).
- R8: With `frame_en_i` low, the outputs and the local generator do not change, whatever `frame_i` holds.
- R9: Lane bits above the active width (bits [7:2] at 80 Mb/s, bits [7:4] at 160 Mb/s) have no effect on any output, and the corresponding mismatch bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Frame clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| frame_en_i | input | 1 | Frame slice valid; advances the local generator |
| rate_sel_i | input | 2 | Line-rate select (00 80, 01 160, 10/11 320 Mb/s) |
| frame_i | input | NCH*8 | One byte per channel; channel 0 in bits [7:0] |
| aligned_o | output | 1 | Group aligned after an uninterrupted clean run |
| xor_mism_o | output | NCH*8 | Per-bit mismatch at zero offset |
| shift_sug_o | output | $clog2(DEPTH)+1 | Suggested frame offset, all ones when none |

## Verification
The hardest situation to reach is a group that is consistently several frames late. It must be separated from one that is merely wrong, and the smallest matching offset must be picked when a narrow 80 Mb/s lane makes several offsets match. The bench keeps a free-running model of the generator sequence. It builds every frame from the word k frames back, including zeros before reset, and computes the expected offset by searching that model. Offsets of 3 and 7 frames at different rates, a corrupted marker, and garbage in the unused lane bits are each driven this way. A disabled stretch with changing input checks that the history is not disturbed.

// File: rtl/ega_pkg.sv
package ega_pkg;
   localparam int LANE_W = 8;
   localparam int WORD_W = 4;

   typedef enum logic [1:0] {
      RATE_80  = 2'b00,
      RATE_160 = 2'b01,
      RATE_320 = 2'b10,
      RATE_RSV = 2'b11
   } rate_e;

   function automatic logic [WORD_W-1:0] word_step(input logic [WORD_W-1:0] s);
      return {s[2:0], s[3] ^ s[2]};
   endfunction

   function automatic logic [LANE_W-1:0] lane_mask(input logic [1:0] rate);
      case (rate)
         RATE_80:  return 8'h03;
         RATE_160: return 8'h0F;
         default:  return 8'hFF;
      endcase
   endfunction

   function automatic logic [LANE_W-1:0] lane_word(input logic [1:0] rate,
                                                   input logic [WORD_W-1:0] w);
      case (rate)
         RATE_80:  return {6'b0, w[1:0]};
         RATE_160: return {4'b0, w};
         default:  return {w, w};
      endcase
   endfunction

   function automatic logic [LANE_W-1:0] lane_marker(input logic [1:0] rate);
      case (rate)
         RATE_80:  return 8'h02;
         RATE_160: return 8'h08;
         default:  return 8'h80;
      endcase
   endfunction
endpackage

// File: rtl/ega_history.sv
module ega_history
   import ega_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic                           clk_i,
   input  logic                           rst_ni,
   input  logic                           adv_i,
   output logic [DEPTH-1:0][WORD_W-1:0]   words_o
);
   logic [WORD_W-1:0] hist_q [DEPTH];

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         hist_q[0] <= 4'b0001;
         for (int k = 1; k < DEPTH; k++) hist_q[k] <= '0;
      end else if (adv_i) begin
         hist_q[0] <= word_step(hist_q[0]);
         for (int k = 1; k < DEPTH; k++) hist_q[k] <= hist_q[k-1];
      end
   end

   for (genvar k = 0; k < DEPTH; k++) begin : g_out
      assign words_o[k] = hist_q[k];
   end
endmodule

// File: rtl/ega_offset_match.sv
module ega_offset_match
   import ega_pkg::*;
#(
   parameter int NCH   = 3,
   parameter int DEPTH = 16,
   parameter int SHW   = 5
) (
   input  logic [NCH*LANE_W-1:0]          frame_i,
   input  logic [1:0]                     rate_i,
   input  logic [DEPTH-1:0][WORD_W-1:0]   words_i,
   output logic                           any_o,
   output logic [SHW-1:0]                 first_o
);
   logic [LANE_W-1:0] mask;
   logic              mark_ok;
   logic [DEPTH-1:0]  hit;

   assign mask    = lane_mask(rate_i);
   assign mark_ok = ((frame_i[LANE_W-1:0] ^ lane_marker(rate_i)) & mask) == '0;

   for (genvar k = 0; k < DEPTH; k++) begin : g_pos
      logic [NCH-1:1] lane_ok;
      for (genvar j = 1; j < NCH; j++) begin : g_lane
         assign lane_ok[j] =
            ((frame_i[j*LANE_W +: LANE_W] ^ lane_word(rate_i, words_i[k])) & mask) == '0;
      end
      assign hit[k] = mark_ok & (&lane_ok);
   end

   always_comb begin
      first_o = '1;
      for (int k = DEPTH-1; k >= 0; k--) begin
         if (hit[k]) first_o = SHW'(k);
      end
   end

   assign any_o = |hit;
endmodule

// File: rtl/elink_group_aligner.sv
module elink_group_aligner
   import ega_pkg::*;
#(
   parameter int NCH       = 3,
   parameter int DEPTH     = 16,
   parameter int ALIGN_RUN = 16,
   localparam int SHW      = $clog2(DEPTH) + 1,
   localparam int VW       = NCH * LANE_W
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            frame_en_i,
   input  logic [1:0]      rate_sel_i,
   input  logic [VW-1:0]   frame_i,
   output logic            aligned_o,
   output logic [VW-1:0]   xor_mism_o,
   output logic [SHW-1:0]  shift_sug_o
);
   localparam int RUN_W = $clog2(ALIGN_RUN + 1);

   if (NCH < 2) begin : g_bad_nch
      $error("NCH must leave at least one LFSR channel beside the marker");
   end
   if (DEPTH < 2 || DEPTH > 64) begin : g_bad_depth
      $error("DEPTH must lie in 2..64");
   end
   if (ALIGN_RUN < 1) begin : g_bad_run
      $error("ALIGN_RUN must be positive");
   end

   logic [DEPTH-1:0][WORD_W-1:0] words;
   logic                         any_hit;
   logic [SHW-1:0]               first_hit;
   logic [VW-1:0]                mism_d;
   logic [RUN_W-1:0]             run_q;
   logic [LANE_W-1:0]            mask;

   ega_history #(.DEPTH(DEPTH)) u_hist (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .adv_i   (frame_en_i),
      .words_o (words)
   );

   ega_offset_match #(.NCH(NCH), .DEPTH(DEPTH), .SHW(SHW)) u_match (
      .frame_i (frame_i),
      .rate_i  (rate_sel_i),
      .words_i (words),
      .any_o   (any_hit),
      .first_o (first_hit)
   );

   assign mask = lane_mask(rate_sel_i);

   for (genvar j = 0; j < NCH; j++) begin : g_mism
      if (j == 0) begin : g_marker
         assign mism_d[LANE_W-1:0] = (frame_i[LANE_W-1:0] ^ lane_marker(rate_sel_i)) & mask;
      end else begin : g_word
         assign mism_d[j*LANE_W +: LANE_W] =
            (frame_i[j*LANE_W +: LANE_W] ^ lane_word(rate_sel_i, words[0])) & mask;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         run_q       <= '0;
         xor_mism_o  <= '0;
         shift_sug_o <= '1;
      end else if (frame_en_i) begin
         xor_mism_o  <= mism_d;
         shift_sug_o <= any_hit ? first_hit : '1;
         if (|mism_d)                           run_q <= '0;
         else if (run_q != RUN_W'(ALIGN_RUN))   run_q <= run_q + 1'b1;
      end
   end

   assign aligned_o = (run_q == RUN_W'(ALIGN_RUN));
endmodule

// File: rtl/ega_checker.sv
module ega_checker #(
   parameter int NCH   = 3,
   parameter int DEPTH = 16,
   parameter int SHW   = 5
) (
   input logic                 clk_i,
   input logic                 rst_ni,
   input logic                 frame_en_i,
   input logic [1:0]           rate_sel_i,
   input logic                 aligned_o,
   input logic [NCH*8-1:0]     xor_mism_o,
   input logic [SHW-1:0]       shift_sug_o
);
   logic upper80;
   always_comb begin
      upper80 = 1'b0;
      for (int j = 0; j < NCH; j++) upper80 = upper80 | (|xor_mism_o[j*8+2 +: 6]);
   end

   p_aligned_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      aligned_o |-> (xor_mism_o == '0));

   p_rise_enabled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(aligned_o) |-> $past(frame_en_i));

   p_hold_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !frame_en_i |=> ($stable(aligned_o) && $stable(xor_mism_o) && $stable(shift_sug_o)));

   p_aligned_offset_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      aligned_o |-> (shift_sug_o == '0));

   p_shift_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (shift_sug_o < SHW'(DEPTH)) || (&shift_sug_o));

   p_unused_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frame_en_i && rate_sel_i == 2'b00) |=> !upper80);
endmodule

bind elink_group_aligner ega_checker #(.NCH(NCH), .DEPTH(DEPTH), .SHW(SHW)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .frame_en_i  (frame_en_i),
   .rate_sel_i  (rate_sel_i),
   .aligned_o   (aligned_o),
   .xor_mism_o  (xor_mism_o),
   .shift_sug_o (shift_sug_o)
);

// File: tb/elink_group_aligner_bench.sv
module elink_group_aligner_bench;
   localparam int NCH = 3;
   localparam int DEPTH = 16;
   localparam int RUN = 16;
   localparam int VW = NCH * 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic [1:0] rate = 2'b01;
   logic [VW-1:0] frame = '0;
   logic aligned;
   logic [VW-1:0] mism;
   logic [4:0] shift;

   always #5 clk = ~clk;

   elink_group_aligner u_elink_group_aligner (
      .clk_i(clk), .rst_ni(rst_n), .frame_en_i(en), .rate_sel_i(rate),
      .frame_i(frame), .aligned_o(aligned), .xor_mism_o(mism), .shift_sug_o(shift)
   );

   int total = 0;
   int bad = 0;
   logic [3:0] lm [4096];
   int t = 0;
   int run = 0;
   logic [VW-1:0] e_mism = '0;
   logic [4:0] e_shift = 5'h1F;

   function automatic logic [7:0] f_mask(logic [1:0] r);
      return (r == 2'b00) ? 8'h03 : (r == 2'b01) ? 8'h0F : 8'hFF;
   endfunction
   function automatic logic [7:0] f_word(logic [1:0] r, logic [3:0] w);
      return (r == 2'b00) ? {6'b0, w[1:0]} : (r == 2'b01) ? {4'b0, w} : {w, w};
   endfunction
   function automatic logic [7:0] f_mark(logic [1:0] r);
      return (r == 2'b00) ? 8'h02 : (r == 2'b01) ? 8'h08 : 8'h80;
   endfunction
   function automatic logic [3:0] f_hist(int idx);
      return (idx < 0) ? 4'h0 : lm[idx];
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run_frame(string tag, logic [1:0] r, int k, bit bad_mk,
                            logic [7:0] flip1, logic [7:0] junk, bit e);
      logic [VW-1:0] rx;
      logic [7:0] m;
      m = f_mask(r);
      rx[7:0] = (f_mark(r) ^ (bad_mk ? 8'h01 : 8'h00)) | (junk & ~m);
      for (int j = 1; j < NCH; j++)
         rx[j*8 +: 8] = (f_word(r, f_hist(t - k)) | (junk & ~m)) ^ ((j == 1) ? flip1 : 8'h00);
      @(negedge clk);
      rate = r; frame = rx; en = e;
      @(posedge clk);
      #1;
      if (e) begin
         e_mism[7:0] = (rx[7:0] ^ f_mark(r)) & m;
         for (int j = 1; j < NCH; j++)
            e_mism[j*8 +: 8] = (rx[j*8 +: 8] ^ f_word(r, lm[t])) & m;
         e_shift = 5'h1F;
         for (int kk = DEPTH - 1; kk >= 0; kk--) begin
            bit ok;
            ok = ((rx[7:0] ^ f_mark(r)) & m) == 8'h00;
            for (int j = 1; j < NCH; j++)
               if (((rx[j*8 +: 8] ^ f_word(r, f_hist(t - kk))) & m) != 8'h00) ok = 0;
            if (ok) e_shift = 5'(kk);
         end
         if (e_mism != '0) run = 0;
         else if (run < RUN) run++;
         t++;
      end
      check({tag, " R4 mism"}, 32'(mism), 32'(e_mism));
      check({tag, " R6/R7 shift"}, 32'(shift), 32'(e_shift));
      check({tag, " R5 aligned"}, 32'(aligned), 32'(run == RUN));
   endtask

   task automatic t_reset();
      @(negedge clk); rst_n = 1'b0; en = 1'b0;
      @(posedge clk); @(posedge clk); #1;
      check("R1 reset aligned", 32'(aligned), 0);
      check("R1 reset mism", 32'(mism), 0);
      check("R1 reset shift", 32'(shift), 32'h1F);
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic t_align_160();
      for (int i = 0; i < 15; i++) run_frame("align160", 2'b01, 0, 0, 8'h00, 8'h00, 1);
      check("R5 not yet after 15", 32'(aligned), 0);
      run_frame("align160", 2'b01, 0, 0, 8'h00, 8'h00, 1);
      check("R5 set after 16", 32'(aligned), 1);
      check("R2 R6 zero offset", 32'(shift), 0);
      for (int i = 0; i < 3; i++) run_frame("align160", 2'b01, 0, 0, 8'h00, 8'h00, 1);
   endtask

   task automatic t_offset_160();
      for (int i = 0; i < 4; i++) run_frame("offset3", 2'b01, 3, 0, 8'h00, 8'h00, 1);
      check("R6 offset three", 32'(shift), 3);
   endtask

   task automatic t_marker_bad();
      for (int i = 0; i < 2; i++) run_frame("R3 marker", 2'b01, 0, 1, 8'h00, 8'h00, 1);
      check("R7 invalid code", 32'(shift), 32'h1F);
      check("R3 marker mism", 32'(mism[7:0]), 32'h01);
   endtask

   task automatic t_break();
      for (int i = 0; i < 16; i++) run_frame("rebuild", 2'b01, 0, 0, 8'h00, 8'h00, 1);
      check("R5 aligned again", 32'(aligned), 1);
      run_frame("break", 2'b01, 0, 0, 8'h01, 8'h00, 1);
      check("R5 cleared by one miss", 32'(aligned), 0);
      check("R4 lane1 mism", 32'(mism[15:8]), 32'h01);
   endtask

   task automatic t_rate80();
      for (int i = 0; i < 17; i++) run_frame("R9 rate80 junk", 2'b00, 0, 0, 8'h00, 8'hFC, 1);
      check("R9 junk ignored aligned", 32'(aligned), 1);
      check("R2 rate80 shift", 32'(shift), 0);
      for (int i = 0; i < 2; i++) run_frame("R9 rate160 junk", 2'b01, 0, 0, 8'h00, 8'hF0, 1);
   endtask

   task automatic t_rate320();
      for (int i = 0; i < 17; i++) run_frame("R2 rate320", 2'b10, 0, 0, 8'h00, 8'h00, 1);
      check("R2 rate320 aligned", 32'(aligned), 1);
      for (int i = 0; i < 3; i++) run_frame("R6 rate320 off7", 2'b10, 7, 0, 8'h00, 8'h00, 1);
      check("R6 offset seven", 32'(shift), 7);
      for (int i = 0; i < 2; i++) run_frame("R2 rate11", 2'b11, 0, 0, 8'h00, 8'h00, 1);
   endtask

   task automatic t_idle();
      for (int i = 0; i < 16; i++) run_frame("R8 prep", 2'b01, 0, 0, 8'h00, 8'h00, 1);
      for (int i = 0; i < 5; i++) run_frame("R8 idle", 2'b01, 5, 1, 8'h5A, 8'hA0, 0);
      check("R8 held aligned", 32'(aligned), 1);
      for (int i = 0; i < 2; i++) run_frame("R8 resume", 2'b01, 0, 0, 8'h00, 8'h00, 1);
      check("R8 history untouched", 32'(shift), 0);
   endtask

   initial begin
      lm[0] = 4'b0001;
      for (int i = 1; i < 4096; i++) lm[i] = {lm[i-1][2:0], lm[i-1][3] ^ lm[i-1][2]};
      t_reset();
      t_align_160();
      t_offset_160();
      t_marker_bad();
      t_break();
      t_rate80();
      t_rate320();
      t_idle();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1000000;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule